// File: doc/BRIEF.md
# Thermostat Alert Controller

This block watches a stream of 12-bit two's-complement temperature results and decides when the thermostat alert pin must be driven. Each result is compared as a signed number against a low and a high limit, both taken from the upper twelve bits of 16-bit limit registers. An out-of-limit result must repeat for a programmable number of consecutive samples before it counts. The alert then follows one of two modes. In comparator mode the pin tracks an over-temperature state that has hysteresis. In interrupt mode the block latches an event and keeps it until software services it.

In interrupt mode the block also answers the SMBus alert-response read. When the bus engine reports that an alert-response address header was received, the block offers a response byte made of its own 7-bit address and a direction bit. It clears the pending event only if it wins arbitration for that byte. A shutdown bit lets one in-flight conversion finish and then ignores further samples. While the bus runs in I3C mode, the pin is held inactive.

Top module: `thermo_alert`

## Requirements
- R1: Comparisons are signed 12-bit. The sample `temp_i` is compared with bits [15:4] of `tlow_i` and `thigh_i`, and bits [3:0] of the limits are ignored.
- R2: In comparator mode (conf bit1 = 0), the alert becomes active after the qualified count of consecutive samples strictly above the high limit. It becomes inactive after the qualified count of consecutive samples at or below the low limit. Samples between the limits change nothing.
- R3: The qualified count is set by conf bits [4:3]: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 6. Any non-qualifying sample restarts the count.
- R4: `alert_drv_lo_o` = 1 means the open-drain pin is pulled low. With conf bit2 (polarity) = 0, an active alert pulls low. With polarity = 1, an active alert releases the pin and an inactive alert pulls it low.
- R5: In interrupt mode (conf bit1 = 1), a qualified crossing latches the alert. A pulse on `reg_read_i` clears the latched alert. After a crossing, only the opposite limit is watched.
- R6: On `ara_req_i`, the block raises `ara_resp_o` only when it is in interrupt mode with an alert pending. The response byte `ara_byte_o` = {`dev_addr_i`, dir}, where dir = 1 for a high-limit crossing and 0 for a low-limit crossing.
- R7: On `ara_done_i` while responding, a won arbitration (`ara_lost_i` = 0) clears the pending alert. A lost arbitration leaves the alert active.
- R8: With conf bit0 (shutdown) = 1, the first sample is still processed and later samples are ignored until shutdown is cleared.
- R9: While `i3c_mode_i` = 1, the alert pin stays inactive and no alert-response is offered.
- R10: After reset, the alert is inactive, no response is offered, and the high limit is the one watched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | New conversion result strobe |
| temp_i | input | 12 | Conversion result, two's complement |
| tlow_i | input | 16 | Low limit register |
| thigh_i | input | 16 | High limit register |
| conf_i | input | 8 | Configuration: [0] shutdown, [1] mode, [2] polarity, [4:3] fault count |
| i3c_mode_i | input | 1 | Bus currently runs I3C |
| reg_read_i | input | 1 | Register read completed pulse |
| dev_addr_i | input | 7 | Own 7-bit bus address |
| ara_req_i | input | 1 | Alert-response address header received |
| ara_done_i | input | 1 | Alert-response byte finished |
| ara_lost_i | input | 1 | Arbitration lost on the response byte |
| alert_drv_lo_o | output | 1 | Pull alert pin low |
| ara_resp_o | output | 1 | Block is offering an alert-response byte |
| ara_byte_o | output | 8 | Alert-response byte |

## Verification
Some properties are checked on every cycle. The pin is held inactive in I3C mode, and a response appears only after a request made in interrupt mode. The response byte carries the device address. A lost arbitration keeps the pending alert, a won one drops it, and no sample moves the alert state while shutdown is in effect. Other behaviour can only be shown by the bench's scenarios: the fault-count mapping, the counter restarting on a non-qualifying sample, and the signed comparison against masked limits. The same holds for the hysteresis band in comparator mode and the re-arming of the opposite limit in interrupt mode.

// File: rtl/thermo_alert_pkg.sv
package thermo_alert_pkg;
  localparam int unsigned CONF_SD  = 0;
  localparam int unsigned CONF_TM  = 1;
  localparam int unsigned CONF_POL = 2;
  localparam int unsigned CONF_FQ  = 3;
  localparam int unsigned CNT_W    = 3;

  function automatic logic [CNT_W-1:0] fault_need(input logic [1:0] fq);
    case (fq)
      2'd0:    return CNT_W'(1);
      2'd1:    return CNT_W'(2);
      2'd2:    return CNT_W'(4);
      default: return CNT_W'(6);
    endcase
  endfunction
endpackage

// File: rtl/ta_fault_qual.sv
module ta_fault_qual #(
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          hit_i,
  input  logic          clr_i,
  input  logic [CW-1:0] need_i,
  output logic          qual_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;

  assign cnt_nx = cnt_q + CW'(1);
  assign qual_o = step_i & hit_i & (cnt_nx >= need_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (step_i) begin
      if (!hit_i || qual_o)      cnt_q <= '0;
      else                       cnt_q <= cnt_nx;
    end
  end
endmodule

// File: rtl/ta_alert_core.sv
module ta_alert_core #(
  parameter int unsigned TW = 12,
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_valid_i,
  input  logic [TW-1:0] temp_i,
  input  logic [TW-1:0] lo_lim_i,
  input  logic [TW-1:0] hi_lim_i,
  input  logic          tm_i,
  input  logic          sd_i,
  input  logic [CW-1:0] need_i,
  input  logic          clr_i,
  output logic          hot_o,
  output logic          pend_o,
  output logic          dir_o,
  output logic          shut_o
);
  logic hot_q, pend_q, dir_q, shut_q;
  logic accept, over, under, hit, halt, qual;

  assign accept = sample_valid_i & ~shut_q;
  assign over   = $signed(temp_i) >  $signed(hi_lim_i);
  assign under  = $signed(temp_i) <= $signed(lo_lim_i);
  assign hit    = hot_q ? under : over;
  // a latched interrupt freezes qualification until serviced
  assign halt   = tm_i & pend_q;

  ta_fault_qual #(.CW(CW)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (accept & ~halt),
    .hit_i  (hit),
    .clr_i  (halt),
    .need_i (need_i),
    .qual_o (qual)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hot_q  <= 1'b0;
      pend_q <= 1'b0;
      dir_q  <= 1'b0;
      shut_q <= 1'b0;
    end else begin
      if (qual) hot_q <= ~hot_q;
      if (qual && tm_i) begin
        pend_q <= 1'b1;
        dir_q  <= ~hot_q;
      end else if (clr_i) begin
        pend_q <= 1'b0;
      end
      if (!sd_i)               shut_q <= 1'b0;
      else if (sample_valid_i) shut_q <= 1'b1;
    end
  end

  assign hot_o  = hot_q;
  assign pend_o = pend_q;
  assign dir_o  = dir_q;
  assign shut_o = shut_q;
endmodule

// File: rtl/ta_ara_resp.sv
module ta_ara_resp #(
  parameter int unsigned AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          done_i,
  input  logic          lost_i,
  input  logic          eligible_i,
  input  logic [AW-1:0] addr_i,
  input  logic          dir_i,
  output logic          resp_o,
  output logic [AW:0]   byte_o,
  output logic          win_o
);
  logic        resp_q;
  logic [AW:0] byte_q;

  assign win_o = done_i & resp_q & ~lost_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_q <= 1'b0;
      byte_q <= '0;
    end else if (req_i) begin
      resp_q <= eligible_i;
      if (eligible_i) byte_q <= {addr_i, dir_i};
    end else if (done_i) begin
      resp_q <= 1'b0;
    end
  end

  assign resp_o = resp_q;
  assign byte_o = byte_q;
endmodule

// File: rtl/thermo_alert.sv
module thermo_alert
  import thermo_alert_pkg::*;
#(
  parameter int unsigned TW = 12,
  parameter int unsigned LW = 16,
  parameter int unsigned AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_valid_i,
  input  logic [TW-1:0] temp_i,
  input  logic [LW-1:0] tlow_i,
  input  logic [LW-1:0] thigh_i,
  input  logic [7:0]    conf_i,
  input  logic          i3c_mode_i,
  input  logic          reg_read_i,
  input  logic [AW-1:0] dev_addr_i,
  input  logic          ara_req_i,
  input  logic          ara_done_i,
  input  logic          ara_lost_i,
  output logic          alert_drv_lo_o,
  output logic          ara_resp_o,
  output logic [AW:0]   ara_byte_o
);
  localparam int unsigned LIM_LSB = LW - TW;

  logic             tm, sd, pol;
  logic [CNT_W-1:0] need;
  logic             alert_hot, alert_pend, alert_dir, conv_shut;
  logic             ara_win, active, eligible;

  assign tm   = conf_i[CONF_TM];
  assign sd   = conf_i[CONF_SD];
  assign pol  = conf_i[CONF_POL];
  assign need = fault_need(conf_i[CONF_FQ+1:CONF_FQ]);

  ta_alert_core #(.TW(TW), .CW(CNT_W)) u_core (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sample_valid_i (sample_valid_i),
    .temp_i         (temp_i),
    .lo_lim_i       (tlow_i[LW-1:LIM_LSB]),
    .hi_lim_i       (thigh_i[LW-1:LIM_LSB]),
    .tm_i           (tm),
    .sd_i           (sd),
    .need_i         (need),
    .clr_i          ((reg_read_i & tm) | ara_win),
    .hot_o          (alert_hot),
    .pend_o         (alert_pend),
    .dir_o          (alert_dir),
    .shut_o         (conv_shut)
  );

  assign eligible = ~i3c_mode_i & tm & alert_pend;

  ta_ara_resp #(.AW(AW)) u_ara (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (ara_req_i),
    .done_i     (ara_done_i),
    .lost_i     (ara_lost_i),
    .eligible_i (eligible),
    .addr_i     (dev_addr_i),
    .dir_i      (alert_dir),
    .resp_o     (ara_resp_o),
    .byte_o     (ara_byte_o),
    .win_o      (ara_win)
  );

  assign active         = ~i3c_mode_i & (tm ? alert_pend : alert_hot);
  assign alert_drv_lo_o = pol ? ~active : active;
endmodule

// File: rtl/thermo_alert_chk.sv
module thermo_alert_chk #(
  parameter int unsigned AW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sample_valid_i,
  input logic [7:0]    conf_i,
  input logic          i3c_mode_i,
  input logic          reg_read_i,
  input logic [AW-1:0] dev_addr_i,
  input logic          ara_req_i,
  input logic          ara_done_i,
  input logic          ara_lost_i,
  input logic          alert_drv_lo_o,
  input logic          ara_resp_o,
  input logic [AW:0]   ara_byte_o,
  input logic          alert_hot,
  input logic          alert_pend,
  input logic          conv_shut
);
  a_r9_i3c_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i3c_mode_i |-> (alert_drv_lo_o == conf_i[2]));

  a_r6_resp_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ara_resp_o) |-> $past(ara_req_i && conf_i[1] && !i3c_mode_i));

  a_r6_resp_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ara_resp_o) |-> (ara_byte_o[AW:1] == $past(dev_addr_i)));

  a_r7_lost_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ara_done_i && ara_lost_i && !reg_read_i && alert_pend) |=> alert_pend);

  a_r7_win_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ara_done_i && !ara_lost_i && ara_resp_o && alert_pend) |=> !alert_pend);

  a_r8_shut_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_shut && sample_valid_i) |=> $stable(alert_hot));
endmodule

bind thermo_alert thermo_alert_chk #(.AW(AW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .conf_i         (conf_i),
  .i3c_mode_i     (i3c_mode_i),
  .reg_read_i     (reg_read_i),
  .dev_addr_i     (dev_addr_i),
  .ara_req_i      (ara_req_i),
  .ara_done_i     (ara_done_i),
  .ara_lost_i     (ara_lost_i),
  .alert_drv_lo_o (alert_drv_lo_o),
  .ara_resp_o     (ara_resp_o),
  .ara_byte_o     (ara_byte_o),
  .alert_hot      (alert_hot),
  .alert_pend     (alert_pend),
  .conv_shut      (conv_shut)
);

// File: tb/tb_thermo_alert.sv
`timescale 1ns/1ps
module tb_thermo_alert;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sample_valid, i3c, reg_read, ara_req, ara_done, ara_lost;
  logic [11:0] temp;
  logic [15:0] tlow, thigh;
  logic [7:0]  conf;
  logic [6:0]  addr;
  logic        drv_lo, resp;
  logic [7:0]  rbyte;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [11:0] T_HOT = 12'h510, T_MID = 12'h4C0, T_COLD = 12'h4A0;

  always #5 clk = ~clk;

  thermo_alert dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(sample_valid), .temp_i(temp),
    .tlow_i(tlow), .thigh_i(thigh), .conf_i(conf), .i3c_mode_i(i3c),
    .reg_read_i(reg_read), .dev_addr_i(addr), .ara_req_i(ara_req),
    .ara_done_i(ara_done), .ara_lost_i(ara_lost), .alert_drv_lo_o(drv_lo),
    .ara_resp_o(resp), .ara_byte_o(rbyte)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mkconf(input logic [1:0] f, input logic pol,
                                        input logic tm, input logic sd);
    return {3'b000, f, pol, tm, sd};
  endfunction

  function automatic logic pin_lo(input logic act, input logic pol);
    return pol ? ~act : act;
  endfunction

  task automatic do_reset(input logic [7:0] c);
    rst_n = 1'b0; sample_valid = 0; i3c = 0; reg_read = 0;
    ara_req = 0; ara_done = 0; ara_lost = 0; temp = '0;
    tlow = 16'h4B00; thigh = 16'h5000; conf = c; addr = 7'h48;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic sample(input logic [11:0] t);
    @(negedge clk); temp = t; sample_valid = 1'b1;
    @(negedge clk); sample_valid = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); reg_read = 1'b1;
    @(negedge clk); reg_read = 1'b0;
  endtask

  task automatic do_ara(input logic lost, output logic r, output logic [7:0] b);
    @(negedge clk); ara_req = 1'b1;
    @(negedge clk); ara_req = 1'b0; r = resp; b = rbyte;
    ara_done = 1'b1; ara_lost = lost;
    @(negedge clk); ara_done = 1'b0; ara_lost = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(mkconf(2'd0, 0, 0, 0));
    chk("R10 pin idle after reset", drv_lo, 0);
    chk("R10 no response after reset", resp, 0);
    sample(T_HOT);
    chk("R10 high limit watched first", drv_lo, 1);
  endtask

  task automatic t_comparator();
    do_reset(mkconf(2'd0, 0, 0, 0));
    sample(12'h500);
    chk("R2 equal to high is not over", drv_lo, 0);
    sample(T_HOT);
    chk("R2 above high asserts", drv_lo, 1);
    sample(T_MID);
    chk("R2 between limits holds", drv_lo, 1);
    sample(12'h4B0);
    chk("R2 equal to low deasserts", drv_lo, 0);
    sample(T_MID);
    chk("R2 between limits stays idle", drv_lo, 0);
  endtask

  task automatic t_fault();
    for (int f = 0; f < 4; f++) begin
      int need;
      need = (f == 0) ? 1 : (f == 1) ? 2 : (f == 2) ? 4 : 6;
      do_reset(mkconf(2'(f), 0, 0, 0));
      for (int i = 0; i < need - 1; i++) sample(T_HOT);
      chk($sformatf("R3 f=%0d short run idle", f), drv_lo, 0);
      if (need > 1) begin
        sample(T_MID);
        for (int i = 0; i < need - 1; i++) sample(T_HOT);
        chk($sformatf("R3 f=%0d count restarted", f), drv_lo, 0);
      end
      sample(T_HOT);
      chk($sformatf("R3 f=%0d qualified", f), drv_lo, 1);
    end
  endtask

  task automatic t_pol();
    do_reset(mkconf(2'd0, 1, 0, 0));
    chk("R4 pol=1 idle pulls low", drv_lo, 1);
    sample(T_HOT);
    chk("R4 pol=1 active releases", drv_lo, pin_lo(1, 1));
  endtask

  task automatic t_signed();
    do_reset(mkconf(2'd0, 0, 0, 0));
    thigh = 16'hE70F; tlow = 16'hD80A;
    sample(12'hE70);
    chk("R1 equal masked high not over", drv_lo, 0);
    sample(12'h000);
    chk("R1 zero above negative high", drv_lo, 1);
    sample(12'hD90);
    chk("R1 above negative low holds", drv_lo, 1);
    sample(12'hD80);
    chk("R1 equal masked low releases", drv_lo, 0);
  endtask

  task automatic t_intr();
    do_reset(mkconf(2'd0, 0, 1, 0));
    sample(T_HOT);
    chk("R5 crossing latches", drv_lo, 1);
    sample(T_COLD);
    chk("R5 latched while unserviced", drv_lo, 1);
    do_read();
    chk("R5 read clears", drv_lo, 0);
    sample(T_HOT);
    chk("R5 high no longer armed", drv_lo, 0);
    sample(T_COLD);
    chk("R5 low limit armed", drv_lo, 1);
    do_read();
    sample(T_HOT);
    chk("R5 high rearmed", drv_lo, 1);
  endtask

  task automatic t_ara();
    logic r; logic [7:0] b;
    do_reset(mkconf(2'd0, 0, 1, 0));
    sample(T_HOT);
    do_ara(1'b1, r, b);
    chk("R6 respond when pending", r, 1);
    chk("R6 byte high dir", b, {7'h48, 1'b1});
    chk("R7 lost keeps alert", drv_lo, 1);
    do_ara(1'b0, r, b);
    chk("R6 respond again", r, 1);
    chk("R7 win clears alert", drv_lo, 0);
    sample(T_COLD);
    do_ara(1'b0, r, b);
    chk("R6 byte low dir", b, {7'h48, 1'b0});
    do_ara(1'b0, r, b);
    chk("R6 no response when idle", r, 0);
    do_reset(mkconf(2'd0, 0, 0, 0));
    sample(T_HOT);
    do_ara(1'b0, r, b);
    chk("R6 no response in comparator", r, 0);
    chk("R6 comparator alert kept", drv_lo, 1);
  endtask

  task automatic t_shut();
    do_reset(mkconf(2'd0, 0, 0, 1));
    sample(T_HOT);
    chk("R8 first sample taken", drv_lo, 1);
    sample(T_COLD);
    chk("R8 later sample ignored", drv_lo, 1);
    @(negedge clk); conf = mkconf(2'd0, 0, 0, 0);
    @(negedge clk);
    sample(T_COLD);
    chk("R8 resumes after shutdown cleared", drv_lo, 0);
  endtask

  task automatic t_i3c();
    logic r; logic [7:0] b;
    do_reset(mkconf(2'd0, 0, 1, 0));
    i3c = 1'b1;
    sample(T_HOT);
    chk("R9 pin idle in I3C", drv_lo, 0);
    do_ara(1'b0, r, b);
    chk("R9 no response in I3C", r, 0);
    i3c = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_comparator();
    t_fault();
    t_pol();
    t_signed();
    t_intr();
    t_ara();
    t_shut();
    t_i3c();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule